// File: doc/BRIEF.md
# Coefficient Register Preload Unit

This unit fills a per-polygon coefficient register file before any fragment work for that polygon starts. Each coefficient register holds one varying slot's value for all three vertices of the polygon, plus a width marker and three mode flags. A binding table controls the fill. Each table entry copies a short run of consecutive varying slots into consecutive coefficient registers, so slot order and register order are independent of each other. Any permutation of slots onto registers can then be expressed without changing the shader that reads the registers.

A header travels with the table and holds three counts. The first says how many of the lowest-numbered slots are full 32-bit values; every slot at or above that count is marked as a packed pair of 16-bit values. The second is the number of registers the polygon may bind, and the third is the number of table entries to walk. A start strobe launches the walk. The unit then writes one register per clock, in table order, and raises ready when the last write lands. A malformed header or an entry that overruns its limits sets an error flag and ends the walk early. The register file has one combinational read port. Header, table and vertex inputs must stay stable from the start strobe until ready returns.

Top module: `coef_preload`

## Requirements
- R1: After reset, ready_o is 1, err_o is 0 and every coefficient register reads as zero.
- R2: A start accepted while ready_o is 1, with a valid header and at least one entry, drops ready_o on the next edge. ready_o stays low for exactly as many cycles as registers are written and rises on the edge that writes the last one.
- R3: With default parameters, table entry k occupies bind_tbl_i bits [14k+13:14k]. Within an entry, bits [3:0] are the base slot, [6:4] the count, [10:7] the base register and [13:11] the flags. Slot base+i is copied into register base+i for every i below the count.
- R4: Entries are applied in ascending table order, one register per clock. When two entries target the same register, the later entry's value remains.
- R5: Read data packs vertex 0 in bits [31:0], vertex 1 in [63:32], vertex 2 in [95:64], the half-width marker in bit 96 and the entry's flags (bit 97 perspective, bit 98 flat, bit 99 point sprite) in [99:97].
- R6: The half-width marker of a register is 1 exactly when the slot copied into it has an index greater than or equal to the header's 32-bit slot count.
- R7: A start with a 32-bit slot count of zero, or with more entries than the table holds, sets err_o on the next edge. ready_o stays 1 and no register changes.
- R8: An entry is rejected if any of these holds: its count is 0 or above 4; base register plus count exceeds the header's register total or the file size; or base slot plus count exceeds the slot count. On rejection, err_o is set, earlier writes are kept, no register of that entry is written, and ready_o rises on the edge that would have written the entry's first register.
- R9: A start strobe while ready_o is 0, including in the cycle of the final write, is ignored.
- R10: While a walk runs, each register reads its previous value until the edge that writes it. Registers that no entry targets keep their previous value.
- R11: An accepted start clears err_o. A start with zero entries writes nothing and leaves ready_o at 1.
- R12: A read address at or beyond the number of registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one polygon |
| hdr_n32_i | input | 5 | Count of 32-bit slots |
| hdr_nregs_i | input | 5 | Total registers the polygon may bind |
| hdr_nbind_i | input | 4 | Number of table entries to walk |
| bind_tbl_i | input | 112 | Binding table, 8 entries of 14 bits |
| vtx0_i | input | 512 | Varying slots of vertex 0, 16 x 32 bits |
| vtx1_i | input | 512 | Varying slots of vertex 1 |
| vtx2_i | input | 512 | Varying slots of vertex 2 |
| rd_addr_i | input | 5 | Coefficient register read address |
| rd_data_o | output | 100 | Coefficient register contents |
| ready_o | output | 1 | Idle, file contents complete |
| err_o | output | 1 | Last start was rejected or aborted |

## Verification
The read port and the write port can touch the same register in the same cycle. The bench reads the register that the first write edge targets at the negative edge right after start, and expects the old contents. It reads the same register one cycle later and expects the new value. Start can also collide with the walk itself. The bench pulses start in a mid-walk cycle and again in the cycle of the final write. It judges both pulses by the exact low time of ready, by the file contents afterwards, and by ready staying high one cycle after the final-write pulse.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  localparam int CFP_FLAG_W  = 3;
  localparam int CFP_CNT_W   = 3;
  localparam int CFP_MAX_VEC = 4;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;

  // A binding run is legal when its length is 1..4 and it stays inside
  // both the header's register total, the physical file and the slot array.
  function automatic logic run_fits(int slot_base, int cnt, int reg_base,
                                    int reg_total, int slot_cap, int reg_cap);
    return (cnt >= 1) && (cnt <= CFP_MAX_VEC) &&
           (reg_base + cnt <= reg_total) &&
           (reg_base + cnt <= reg_cap) &&
           (slot_base + cnt <= slot_cap);
  endfunction

  // Width class of a slot: at or above the 32-bit count means packed halves.
  function automatic logic slot_is_half(int slot, int n32);
    return slot >= n32;
  endfunction

  function automatic logic hdr_ok(int n32, int nbind, int bind_cap);
    return (n32 != 0) && (nbind <= bind_cap);
  endfunction

endpackage

// File: rtl/cfp_bind_walker.sv
module cfp_bind_walker
  import cfp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_REGS  = 16,
  parameter int NUM_BIND  = 8,
  parameter int SLOT_W    = 4,
  parameter int REG_W     = 4,
  parameter int BIND_W    = 3,
  parameter int ENT_W     = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [SLOT_W:0]           hdr_n32_i,
  input  logic [REG_W:0]            hdr_nregs_i,
  input  logic [BIND_W:0]           hdr_nbind_i,
  input  logic [NUM_BIND*ENT_W-1:0] bind_tbl_i,
  output logic                      wr_en_o,
  output logic [REG_W-1:0]          wr_reg_o,
  output logic [SLOT_W-1:0]         wr_slot_o,
  output logic [CFP_FLAG_W-1:0]     wr_flags_o,
  output logic                      ready_o,
  output logic                      err_o
);

  localparam int CNT_OFS  = SLOT_W;
  localparam int REG_OFS  = SLOT_W + CFP_CNT_W;
  localparam int FLAG_OFS = SLOT_W + CFP_CNT_W + REG_W;

  walk_state_e       state;
  logic [BIND_W-1:0] idx;
  logic [1:0]        comp;

  logic [ENT_W-1:0]      cur;
  logic [SLOT_W-1:0]     f_slot;
  logic [CFP_CNT_W-1:0]  f_cnt;
  logic [REG_W-1:0]      f_reg;
  logic [CFP_FLAG_W-1:0] f_flags;

  // named events for the assertions
  logic running;
  logic entry_bad;
  logic last_comp;
  logic last_entry;
  logic hdr_fault;
  logic accept;

  assign cur     = bind_tbl_i[idx*ENT_W +: ENT_W];
  assign f_slot  = cur[SLOT_W-1:0];
  assign f_cnt   = cur[CNT_OFS +: CFP_CNT_W];
  assign f_reg   = cur[REG_OFS +: REG_W];
  assign f_flags = cur[FLAG_OFS +: CFP_FLAG_W];

  assign running    = (state == WK_RUN);
  assign entry_bad  = running && (comp == 2'd0) &&
                      !run_fits(int'(f_slot), int'(f_cnt), int'(f_reg),
                                int'(hdr_nregs_i), NUM_SLOTS, NUM_REGS);
  assign last_comp  = (int'(comp) + 1 == int'(f_cnt));
  assign last_entry = (int'(idx) + 1 == int'(hdr_nbind_i));
  assign hdr_fault  = !running && start_i &&
                      !hdr_ok(int'(hdr_n32_i), int'(hdr_nbind_i), NUM_BIND);
  assign accept     = !running && start_i && !hdr_fault && (hdr_nbind_i != '0);

  assign wr_en_o    = running && !entry_bad;
  assign wr_reg_o   = f_reg + REG_W'(comp);
  assign wr_slot_o  = f_slot + SLOT_W'(comp);
  assign wr_flags_o = f_flags;
  assign ready_o    = !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WK_IDLE;
      idx   <= '0;
      comp  <= '0;
      err_o <= 1'b0;
    end else begin
      case (state)
        WK_IDLE: begin
          if (start_i) begin
            if (hdr_fault) begin
              err_o <= 1'b1;
            end else begin
              err_o <= 1'b0;
              if (accept) begin
                state <= WK_RUN;
                idx   <= '0;
                comp  <= '0;
              end
            end
          end
        end
        default: begin
          if (entry_bad) begin
            err_o <= 1'b1;
            state <= WK_IDLE;
          end else if (last_comp) begin
            comp <= '0;
            if (last_entry) state <= WK_IDLE;
            else            idx   <= idx + 1'b1;
          end else begin
            comp <= comp + 1'b1;
          end
        end
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready_o && !err_o);  // R2
  AST_HDR_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fault |=> err_o && ready_o);  // R7
  AST_ABORT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    entry_bad |=> ready_o && err_o);  // R8
  AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ready_o);  // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i && !entry_bad && !(last_comp && last_entry)) |=> !ready_o);  // R9

endmodule

// File: rtl/cfp_slot_gather.sv
module cfp_slot_gather
  import cfp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DW        = 32,
  parameter int SLOT_W    = 4
) (
  input  logic [NUM_SLOTS*DW-1:0] vtx0_i,
  input  logic [NUM_SLOTS*DW-1:0] vtx1_i,
  input  logic [NUM_SLOTS*DW-1:0] vtx2_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [SLOT_W:0]         n32_i,
  output logic [3*DW-1:0]         vals_o,
  output logic                    half_o
);

  localparam int NV = 3;

  logic [NV-1:0][NUM_SLOTS*DW-1:0] vtx;
  assign vtx = {vtx2_i, vtx1_i, vtx0_i};

  for (genvar v = 0; v < NV; v++) begin : g_vtx
    assign vals_o[v*DW +: DW] = vtx[v][slot_i*DW +: DW];
  end

  assign half_o = slot_is_half(int'(slot_i), int'(n32_i));

endmodule

// File: rtl/cfp_coef_file.sv
module cfp_coef_file #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int CF_W     = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] waddr_i,
  input  logic [CF_W-1:0]  wdata_i,
  input  logic [REG_W:0]   raddr_i,
  output logic [CF_W-1:0]  rdata_o
);

  logic [NUM_REGS-1:0][CF_W-1:0] mem;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       mem[r] <= '0;
      else if (we_i && (int'(waddr_i) == r))            mem[r] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < NUM_REGS) ? mem[raddr_i[REG_W-1:0]] : '0;

  AST_FILE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem));  // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));  // R3

endmodule

// File: rtl/coef_preload.sv
module coef_preload
  import cfp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_REGS  = 16,
  parameter int NUM_BIND  = 8,
  parameter int DW        = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int BIND_W   = $clog2(NUM_BIND),
  localparam int ENT_W    = SLOT_W + CFP_CNT_W + REG_W + CFP_FLAG_W,
  localparam int CF_W     = 3*DW + 1 + CFP_FLAG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [SLOT_W:0]           hdr_n32_i,
  input  logic [REG_W:0]            hdr_nregs_i,
  input  logic [BIND_W:0]           hdr_nbind_i,
  input  logic [NUM_BIND*ENT_W-1:0] bind_tbl_i,
  input  logic [NUM_SLOTS*DW-1:0]   vtx0_i,
  input  logic [NUM_SLOTS*DW-1:0]   vtx1_i,
  input  logic [NUM_SLOTS*DW-1:0]   vtx2_i,
  input  logic [REG_W:0]            rd_addr_i,
  output logic [CF_W-1:0]           rd_data_o,
  output logic                      ready_o,
  output logic                      err_o
);

  logic                  wr_fire;
  logic [REG_W-1:0]      wr_reg;
  logic [SLOT_W-1:0]     wr_slot;
  logic [CFP_FLAG_W-1:0] wr_flags;
  logic [3*DW-1:0]       wr_vals;
  logic                  wr_half;
  logic [CF_W-1:0]       wr_word;

  cfp_bind_walker #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .NUM_BIND(NUM_BIND),
    .SLOT_W(SLOT_W), .REG_W(REG_W), .BIND_W(BIND_W), .ENT_W(ENT_W)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .hdr_n32_i(hdr_n32_i), .hdr_nregs_i(hdr_nregs_i), .hdr_nbind_i(hdr_nbind_i),
    .bind_tbl_i(bind_tbl_i),
    .wr_en_o(wr_fire), .wr_reg_o(wr_reg), .wr_slot_o(wr_slot), .wr_flags_o(wr_flags),
    .ready_o(ready_o), .err_o(err_o)
  );

  cfp_slot_gather #(
    .NUM_SLOTS(NUM_SLOTS), .DW(DW), .SLOT_W(SLOT_W)
  ) gather_i (
    .vtx0_i(vtx0_i), .vtx1_i(vtx1_i), .vtx2_i(vtx2_i),
    .slot_i(wr_slot), .n32_i(hdr_n32_i),
    .vals_o(wr_vals), .half_o(wr_half)
  );

  assign wr_word = {wr_flags, wr_half, wr_vals};

  cfp_coef_file #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .CF_W(CF_W)
  ) file_i (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_fire), .waddr_i(wr_reg), .wdata_i(wr_word),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (int'(wr_reg) < int'(hdr_nregs_i)));  // R8
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !ready_o);  // R2

endmodule

// File: tb/coef_preload_tb_top.sv
module coef_preload_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLOTS  = 16;
  localparam int NUM_REGS   = 16;
  localparam int NUM_BIND   = 8;
  localparam int DW         = 32;
  localparam int ENT_W      = 14;
  localparam int CF_W       = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] n32 = '0;
  logic [4:0] nregs = '0;
  logic [3:0] nbind = '0;
  logic [NUM_BIND*ENT_W-1:0] tbl = '0;
  logic [NUM_SLOTS*DW-1:0] vx0 = '0, vx1 = '0, vx2 = '0;
  logic [4:0] rd_addr = '0;
  logic [CF_W-1:0] rd_data;
  logic ready, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_preload dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .hdr_n32_i(n32), .hdr_nregs_i(nregs), .hdr_nbind_i(nbind),
    .bind_tbl_i(tbl), .vtx0_i(vx0), .vtx1_i(vx1), .vtx2_i(vx2),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready), .err_o(err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int addr;
    logic [CF_W-1:0] exp;
    string tag;
  } sb_item_t;

  sb_item_t sbq[$];
  bit mon_busy = 0;
  logic [CF_W-1:0] model [NUM_REGS];

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [ENT_W-1:0] mk(int s, int c, int r, int f);
    return {3'(f), 4'(r), 3'(c), 4'(s)};
  endfunction

  task automatic set_vtx(int seed);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      vx0[s*DW +: DW] = 32'(seed * 32'h9E37_79B1) ^ 32'(s * 32'h0001_0203) ^ 32'h1000_0000;
      vx1[s*DW +: DW] = 32'(seed * 32'h7F4A_7C15) ^ 32'(s * 32'h0102_0001) ^ 32'h2000_0000;
      vx2[s*DW +: DW] = 32'(seed * 32'h85EB_CA6B) ^ 32'(s * 32'h0300_0105) ^ 32'h4000_0000;
    end
  endtask

  // Expected outcome built from R3..R8, R11
  task automatic model_run(output int exp_low, output bit exp_err);
    bit stop;
    exp_low = 0;
    exp_err = 0;
    stop = 0;
    if (n32 == 0 || int'(nbind) > NUM_BIND) begin
      exp_err = 1;
      return;
    end
    for (int k = 0; k < int'(nbind); k++) begin
      if (!stop) begin
        logic [ENT_W-1:0] e;
        int s, c, r, f;
        e = tbl[k*ENT_W +: ENT_W];
        s = int'(e[3:0]); c = int'(e[6:4]); r = int'(e[10:7]); f = int'(e[13:11]);
        if (c < 1 || c > 4 || r + c > int'(nregs) || r + c > NUM_REGS || s + c > NUM_SLOTS) begin
          exp_err = 1;
          exp_low++;
          stop = 1;
        end else begin
          for (int i = 0; i < c; i++) begin
            model[r+i] = {3'(f), ((s+i) >= int'(n32)) ? 1'b1 : 1'b0,
                          vx2[(s+i)*DW +: DW], vx1[(s+i)*DW +: DW], vx0[(s+i)*DW +: DW]};
            exp_low++;
          end
        end
      end
    end
  endtask

  task automatic drain();
    while (sbq.size() != 0 || mon_busy) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_all(string tag);
    for (int a = 0; a < NUM_REGS; a++) sbq.push_back('{a, model[a], tag});
    sbq.push_back('{NUM_REGS, '0, "R12 out-of-range read"});
    drain();
  endtask

  // mid: register to read around the first write edge (-1: none)
  // pulse_at: busy cycle in which a stray start is pulsed (0: none)
  task automatic run_poly(string tag, int mid, int pulse_at);
    int exp_low, n;
    bit exp_err;
    logic [CF_W-1:0] oldv, newv;
    oldv = (mid >= 0) ? model[mid] : '0;
    model_run(exp_low, exp_err);
    newv = (mid >= 0) ? model[mid] : '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      start = 1'b0;
      if (mid >= 0 && n == 1) begin
        rd_addr = 5'(mid); #1;
        check(rd_data == oldv, "R10 old value before write edge", 128'(rd_data), 128'(oldv));
      end
      if (mid >= 0 && n == 2) begin
        rd_addr = 5'(mid); #1;
        check(rd_data == newv, "R10 new value after write edge", 128'(rd_data), 128'(newv));
      end
      if (n == pulse_at) start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    check(n == exp_low, {tag, " R2 ready low cycles"}, 128'(n), 128'(exp_low));
    check(err == exp_err, {tag, " R8 error flag"}, 128'(err), 128'(exp_err));
    if (pulse_at > 0) begin
      @(negedge clk);
      check(ready == 1'b1, "R9 start while busy ignored", 128'(ready), 128'd1);
    end
    push_all(tag);
  endtask

  // monitor: pops expected items and compares at the read port
  initial begin
    forever begin
      @(posedge clk);
      if (sbq.size() > 0) begin
        sb_item_t it;
        mon_busy = 1;
        it = sbq.pop_front();
        @(negedge clk);
        rd_addr = 5'(it.addr);
        #1;
        check(rd_data == it.exp, it.tag, 128'(rd_data), 128'(it.exp));
        mon_busy = 0;
      end
    end
  end

  initial begin
    for (int a = 0; a < NUM_REGS; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1 ready after reset", 128'(ready), 128'd1);
    check(err == 1'b0, "R1 err after reset", 128'(err), 128'd0);
    push_all("R1 reset contents zero");

    // identity order, mixed widths: R3 R5 R6
    set_vtx(1);
    n32 = 5'd4; nregs = 5'd10; nbind = 4'd3; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(0, 4, 0, 1);
    tbl[1*ENT_W +: ENT_W] = mk(4, 4, 4, 2);
    tbl[2*ENT_W +: ENT_W] = mk(8, 2, 8, 4);
    run_poly("R3 R5 R6 identity", -1, 0);

    // permutation, overlap, read/write collision, stray start: R4 R10 R9
    set_vtx(2);
    n32 = 5'd11; nregs = 5'd6; nbind = 4'd3; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(10, 3, 0, 3);
    tbl[1*ENT_W +: ENT_W] = mk(0, 3, 3, 5);
    tbl[2*ENT_W +: ENT_W] = mk(15, 1, 1, 7);
    run_poly("R4 permuted overlap", 0, 2);

    // start in the cycle of the final write: R9
    set_vtx(3);
    n32 = 5'd1; nregs = 5'd4; nbind = 4'd1; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(5, 2, 2, 0);
    run_poly("R9 final-cycle start", -1, 2);

    // header faults: R7
    set_vtx(4);
    n32 = 5'd0; nregs = 5'd16; nbind = 4'd1;
    tbl[0*ENT_W +: ENT_W] = mk(0, 4, 0, 1);
    run_poly("R7 zero 32-bit count", -1, 0);
    n32 = 5'd2; nbind = 4'd9;
    run_poly("R7 too many entries", -1, 0);

    // zero entries clears error: R11
    nbind = 4'd0;
    run_poly("R11 empty table", -1, 0);
    check(err == 1'b0, "R11 err cleared", 128'(err), 128'd0);

    // entry overruns register total: R8
    set_vtx(5);
    n32 = 5'd3; nregs = 5'd4; nbind = 4'd2; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(0, 2, 0, 2);
    tbl[1*ENT_W +: ENT_W] = mk(2, 2, 3, 2);
    run_poly("R8 register overrun", -1, 0);

    // zero-count entry: R8
    set_vtx(6);
    nregs = 5'd16; nbind = 4'd2; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(0, 0, 0, 1);
    run_poly("R8 zero count", -1, 0);

    // slot overrun after a good entry: R8
    set_vtx(7);
    nbind = 4'd2; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(1, 1, 12, 6);
    tbl[1*ENT_W +: ENT_W] = mk(14, 3, 0, 6);
    run_poly("R8 slot overrun", -1, 0);

    // clean polygon after error clears it: R11 R2
    set_vtx(8);
    n32 = 5'd16; nregs = 5'd16; nbind = 4'd4; tbl = '0;
    tbl[0*ENT_W +: ENT_W] = mk(12, 4, 12, 1);
    tbl[1*ENT_W +: ENT_W] = mk(0, 4, 8, 2);
    tbl[2*ENT_W +: ENT_W] = mk(4, 4, 0, 4);
    tbl[3*ENT_W +: ENT_W] = mk(8, 4, 4, 0);
    run_poly("R11 full file recovery", -1, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule